// File: doc/BRIEF.md
# Ethernet Transmit Frame Finisher

This block sits on a byte-wide transmit stream between a packet source and the line side. Each frame is framed by first and last markers. The block passes the frame bytes through with one cycle of latency. When the frame is short and padding is selected, it adds zero bytes. When checksum insertion is selected, it appends the 32-bit Ethernet frame check sequence. While it emits pad or checksum bytes it holds the source off by dropping its ready output.

The length of every frame is compared with a programmable 14-bit limit. The limit covers everything on the line plus a fixed transmit-header allowance. A frame inside the limit produces a one-cycle "sent" pulse, and a frame over the limit produces an error pulse instead. Both pulses come with the frame's line byte count for a statistics block.

The transmit enable and the pad and checksum selections are sampled only when a frame starts. A frame that has begun always finishes. A synchronous clear input returns the whole path to its power-on state in one cycle.

Top module: `tx_frame_finisher`

## Requirements
- R1: With padding and checksum both selected, a frame of fewer than 60 data bytes is extended with bytes of value 0x00 to 60 bytes, so that 64 bytes including the checksum reach the line.
- R2: With checksum selected, four bytes follow the data and pad. They hold the inverted CRC-32 over data and pad (reflected polynomial 0xEDB88320, all-ones start), sent least-significant byte first. With checksum clear, nothing is appended.
- R3: A frame of 60 or more data bytes gets no pad bytes.
- R4: The padding selection has no effect while checksum insertion is clear: the frame leaves with its own length.
- R5: The enable is honoured only between frames. While idle and disabled, `in_ready` stays low and nothing is emitted. Clearing the enable mid-frame does not cut the frame short.
- R6: On the cycle carrying the frame's last byte, `frame_sent` pulses if line bytes plus `HDR_BYTES` (16) is at most `cfg_max_total`. Otherwise `len_error` pulses instead. The two never pulse together.
- R7: A one-cycle `soft_clear` pulse ends any frame in progress. The next cycle has no output byte and is ready for a new frame.
- R8: `stat_bytes`, valid with either end pulse, equals the number of bytes the frame put on the line.
- R9: Each accepted byte appears on the output one cycle later. `in_ready` stays low for exactly the pad plus checksum cycles after a frame's last byte, and `out_first` marks the first output byte.
- R10: After reset, no output byte, end pulse or error is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clear | input | 1 | One-cycle synchronous return to power-on state |
| cfg_enable | input | 1 | Transmit enable, sampled at frame start |
| cfg_pad | input | 1 | Pad short frames (needs cfg_fcs) |
| cfg_fcs | input | 1 | Append checksum |
| cfg_max_total | input | 14 | Limit for line bytes plus transmit header |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_first | input | 1 | First byte of frame |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Line byte valid |
| out_data | output | 8 | Line byte |
| out_first | output | 1 | First line byte of frame |
| out_last | output | 1 | Last line byte of frame |
| frame_sent | output | 1 | Frame finished within the length limit |
| len_error | output | 1 | Frame finished over the length limit |
| stat_bytes | output | 16 | Line byte count of the finished frame |

## Verification
The bench builds the block with the default parameters: a 64-byte minimum, a 16-byte header allowance and 16-bit counts. It programs `cfg_max_total` to 80 for part of the run, so that a frame of 60 data bytes with checksum sits exactly on the limit and one of 61 bytes goes one byte over, using only short frames. Frames of 59, 60 and 70 data bytes reach both sides of the padding threshold. The 20-byte frames show the full 40-cycle pad tail.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } txf_state_e;

  localparam logic [31:0] CRC_REFL_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  // one byte of the reflected CRC-32, eight shift steps unrolled
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_REFL_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/txf_fcs_gen.sv
module txf_fcs_gen
  import txf_pkg::*;
(
  input  logic        clk,
  input  logic        clr,
  input  logic        restart,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      crc_q <= CRC_SEED;
    end else if (en) begin
      crc_q <= crc_step_byte(restart ? CRC_SEED : crc_q, din);
    end
  end

  assign fcs = ~crc_q;

endmodule

// File: rtl/txf_seq.sv
module txf_seq
  import txf_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int HDR_BYTES = 16,
  parameter int LEN_W     = 14,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             cfg_enable,
  input  logic             cfg_pad,
  input  logic             cfg_fcs,
  input  logic [LEN_W-1:0] cfg_max_total,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  output logic             in_ready,
  input  logic [31:0]      fcs_val,
  output logic             crc_en,
  output logic             crc_restart,
  output logic [7:0]       crc_din,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             out_last,
  output logic             frame_sent,
  output logic             len_error,
  output logic [CNT_W-1:0] stat_bytes
);
  localparam int FCS_BYTES = 4;
  localparam logic [CNT_W-1:0] DATA_MIN = CNT_W'(MIN_FRAME - FCS_BYTES);
  localparam logic [CNT_W:0]   HDR_EXT  = (CNT_W+1)'(HDR_BYTES);

  txf_state_e       st_q;
  logic             busy_q, pad_q, fcs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       idx_q;

  logic             accept, pad_now, fcs_now, need_pad, fin_go, fin_over;
  logic [CNT_W-1:0] cnt_base, cnt_inc, cnt_step, fin_n;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign in_ready = (st_q == ST_DATA) && (busy_q || cfg_enable);
  assign accept   = in_valid && in_ready;
  // pad and checksum selections are frozen at the first byte
  assign pad_now  = busy_q ? pad_q : (cfg_pad & cfg_fcs);
  assign fcs_now  = busy_q ? fcs_q : cfg_fcs;
  assign cnt_base = busy_q ? cnt_q : '0;
  assign cnt_inc  = sat_inc(cnt_base);
  assign cnt_step = sat_inc(cnt_q);
  assign need_pad = pad_now && (cnt_inc < DATA_MIN);

  assign crc_en      = accept || (st_q == ST_PAD);
  assign crc_restart = accept && !busy_q;
  assign crc_din     = accept ? in_data : 8'h00;

  always_comb begin
    fin_go = 1'b0;
    fin_n  = cnt_step;
    if (st_q == ST_DATA) begin
      fin_go = accept && in_last && !need_pad && !fcs_now;
      fin_n  = cnt_inc;
    end else if (st_q == ST_FCS) begin
      fin_go = (idx_q == 2'd3);
    end
  end

  assign fin_over = ({1'b0, fin_n} + HDR_EXT) >
                    {{(CNT_W+1-LEN_W){1'b0}}, cfg_max_total};

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q       <= ST_DATA;
      busy_q     <= 1'b0;
      pad_q      <= 1'b0;
      fcs_q      <= 1'b0;
      cnt_q      <= '0;
      idx_q      <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      frame_sent <= 1'b0;
      len_error  <= 1'b0;
      stat_bytes <= '0;
    end else begin
      out_valid  <= 1'b0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      frame_sent <= 1'b0;
      len_error  <= 1'b0;
      case (st_q)
        ST_DATA: if (accept) begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          out_first <= !busy_q;
          busy_q    <= 1'b1;
          pad_q     <= pad_now;
          fcs_q     <= fcs_now;
          cnt_q     <= cnt_inc;
          if (in_last && need_pad) begin
            st_q <= ST_PAD;
          end else if (in_last && fcs_now) begin
            st_q  <= ST_FCS;
            idx_q <= '0;
          end
        end
        ST_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          cnt_q     <= cnt_step;
          if (cnt_step == DATA_MIN) begin
            st_q  <= ST_FCS;
            idx_q <= '0;
          end
        end
        ST_FCS: begin
          out_valid <= 1'b1;
          out_data  <= fcs_val[8*idx_q +: 8];
          cnt_q     <= cnt_step;
          idx_q     <= idx_q + 2'd1;
          if (idx_q == 2'd3) st_q <= ST_DATA;
        end
        default: st_q <= ST_DATA;
      endcase
      if (fin_go) begin
        out_last   <= 1'b1;
        busy_q     <= 1'b0;
        stat_bytes <= fin_n;
        frame_sent <= !fin_over;
        len_error  <= fin_over;
      end
    end
  end

  // ---------------- assertions ----------------
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (clr)
    (st_q == ST_PAD) |=> (out_valid && out_data == 8'h00));

  p_min_len_r1: assert property (@(posedge clk) disable iff (clr)
    (out_last && pad_q) |-> (stat_bytes >= CNT_W'(MIN_FRAME)));

  p_pad_needs_fcs_r4: assert property (@(posedge clk) disable iff (clr)
    (st_q == ST_PAD) |-> fcs_q);

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (clr)
    (!busy_q && !cfg_enable) |-> !in_ready);

  p_end_pulse_r6: assert property (@(posedge clk) disable iff (clr)
    (frame_sent || len_error) |-> (out_last && !(frame_sent && len_error)));

  p_first_marker_r9: assert property (@(posedge clk) disable iff (clr)
    (accept && !busy_q) |-> in_first);

  p_latency_r9: assert property (@(posedge clk) disable iff (clr)
    accept |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: rtl/tx_frame_finisher.sv
module tx_frame_finisher #(
  parameter int MIN_FRAME = 64,
  parameter int HDR_BYTES = 16,
  parameter int LEN_W     = 14,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_clear,
  input  logic             cfg_enable,
  input  logic             cfg_pad,
  input  logic             cfg_fcs,
  input  logic [LEN_W-1:0] cfg_max_total,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             out_last,
  output logic             frame_sent,
  output logic             len_error,
  output logic [CNT_W-1:0] stat_bytes
);
  logic        clr;
  logic        crc_en, crc_restart;
  logic [7:0]  crc_din;
  logic [31:0] fcs_val;

  assign clr = rst || soft_clear;

  txf_fcs_gen u_fcs (
    .clk     (clk),
    .clr     (clr),
    .restart (crc_restart),
    .en      (crc_en),
    .din     (crc_din),
    .fcs     (fcs_val)
  );

  txf_seq #(
    .MIN_FRAME (MIN_FRAME),
    .HDR_BYTES (HDR_BYTES),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk           (clk),
    .clr           (clr),
    .cfg_enable    (cfg_enable),
    .cfg_pad       (cfg_pad),
    .cfg_fcs       (cfg_fcs),
    .cfg_max_total (cfg_max_total),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_first      (in_first),
    .in_last       (in_last),
    .in_ready      (in_ready),
    .fcs_val       (fcs_val),
    .crc_en        (crc_en),
    .crc_restart   (crc_restart),
    .crc_din       (crc_din),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_first     (out_first),
    .out_last      (out_last),
    .frame_sent    (frame_sent),
    .len_error     (len_error),
    .stat_bytes    (stat_bytes)
  );

endmodule

// File: tb/tb_tx_frame_finisher.sv
module tb_tx_frame_finisher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_clear = 1'b0;
  logic        cfg_enable = 1'b1;
  logic        cfg_pad = 1'b0;
  logic        cfg_fcs = 1'b0;
  logic [13:0] cfg_max_total = 14'h2422;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_first = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready, out_valid, out_first, out_last, frame_sent, len_error;
  logic [7:0]  out_data;
  logic [15:0] stat_bytes;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] got[$];
  int firsts, sents, errs, last_stat;

  tx_frame_finisher dut (
    .clk(clk), .rst(rst), .soft_clear(soft_clear),
    .cfg_enable(cfg_enable), .cfg_pad(cfg_pad), .cfg_fcs(cfg_fcs),
    .cfg_max_total(cfg_max_total),
    .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last),
    .frame_sent(frame_sent), .len_error(len_error), .stat_bytes(stat_bytes)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) got.push_back(out_data);
      if (out_valid && out_first) firsts++;
      if (frame_sent) begin sents++; last_stat = int'(stat_bytes); end
      if (len_error)  begin errs++;  last_stat = int'(stat_bytes); end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ q[i][b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  // drives one frame, checks line bytes, tail, end pulse and count
  task automatic run_frame(input int n, input int seed, input bit pad, input bit fcs,
                           input int drop_at, input string tag);
    logic [7:0] exp[$];
    int tail = 0;
    int total, guard;
    logic [31:0] f;
    bit bytes_ok = 1;
    @(negedge clk);
    cfg_pad = pad; cfg_fcs = fcs;
    got.delete(); firsts = 0; sents = 0; errs = 0; last_stat = -1;
    for (int i = 0; i < n; i++) exp.push_back(8'((seed + 13 * i) & 8'hFF));
    for (int i = 0; i < n; ) begin
      if (in_ready) begin
        in_valid = 1'b1; in_data = exp[i];
        in_first = (i == 0); in_last = (i == n - 1);
        if (i == drop_at) cfg_enable = 1'b0;
        i++;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    guard = 0;
    while (!(out_valid && out_last) && guard < 300) begin
      if (!in_ready) tail++;
      guard++;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    if (pad && fcs) while (exp.size() < 60) exp.push_back(8'h00);
    if (fcs) begin
      f = ref_crc(exp);
      for (int k = 0; k < 4; k++) exp.push_back(f[8*k +: 8]);
    end
    total = exp.size();
    check(got.size() == total, {tag, " line length"}, got.size(), total);
    for (int i = 0; i < total && i < got.size(); i++)
      if (got[i] !== exp[i]) bytes_ok = 0;
    check(bytes_ok, {tag, " R2 line bytes match"}, int'(bytes_ok), 1);
    check(tail == total - n, {tag, " R9 ready-low tail"}, tail, total - n);
    check(firsts == 1, {tag, " R9 out_first count"}, firsts, 1);
    if (total + 16 <= int'(cfg_max_total)) begin
      check(sents == 1 && errs == 0, {tag, " R6 sent pulse"}, sents, 1);
    end else begin
      check(errs == 1 && sents == 0, {tag, " R6 error pulse"}, errs, 1);
    end
    check(last_stat == total, {tag, " R8 stat_bytes"}, last_stat, total);
  endtask

  task automatic t_reset;
    check(out_valid == 0, "R10 out_valid after reset", int'(out_valid), 0);
    check(frame_sent == 0 && len_error == 0, "R10 end pulses after reset",
          int'(frame_sent) + int'(len_error), 0);
    check(in_ready == 1, "R10 ready when enabled", int'(in_ready), 1);
  endtask

  task automatic t_disabled_idle;
    int seen_ready = 0;
    @(negedge clk);
    cfg_enable = 1'b0; got.delete();
    in_valid = 1'b1; in_data = 8'h5A; in_first = 1'b1; in_last = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (in_ready) seen_ready++;
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    @(negedge clk);
    check(seen_ready == 0, "R5 ready held low while disabled", seen_ready, 0);
    check(got.size() == 0, "R5 nothing emitted while disabled", got.size(), 0);
    cfg_enable = 1'b1;
  endtask

  task automatic t_drop_mid_frame;
    run_frame(30, 7, 1, 1, 5, "R5 disable mid-frame");
    check(in_ready == 0, "R5 held after frame", int'(in_ready), 0);
    cfg_enable = 1'b1;
  endtask

  task automatic t_soft_clear;
    @(negedge clk);
    cfg_pad = 1; cfg_fcs = 1;
    for (int i = 0; i < 10; ) begin
      if (in_ready) begin
        in_valid = 1'b1; in_data = 8'(i); in_first = (i == 0); in_last = 1'b0; i++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0;
    soft_clear = 1'b1;
    @(negedge clk);
    soft_clear = 1'b0;
    check(out_valid == 0, "R7 output stops after clear", int'(out_valid), 0);
    check(in_ready == 1, "R7 ready for new frame", int'(in_ready), 1);
    run_frame(20, 99, 1, 1, -1, "R7 frame after clear");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_frame(20, 1,  1, 1, -1, "R1 short padded");
    run_frame(59, 3,  1, 1, -1, "R1 59 bytes padded");
    run_frame(60, 5,  1, 1, -1, "R3 60 bytes unpadded");
    run_frame(20, 11, 1, 0, -1, "R4 pad without fcs");
    run_frame(70, 17, 0, 1, -1, "R2 fcs only");
    run_frame(10, 23, 0, 0, -1, "R2 plain");
    run_frame(1,  29, 1, 1, -1, "R1 single byte");
    cfg_max_total = 14'd80;
    run_frame(60, 31, 0, 1, -1, "R6 on limit");
    run_frame(61, 37, 0, 1, -1, "R6 over limit");
    cfg_max_total = 14'h2422;
    t_disabled_idle();
    t_drop_mid_frame();
    t_soft_clear();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule